// File: doc/BRIEF.md
# Swallow-Counter Feedback Divider

This block sits in the feedback path of a radio tuning PLL. It takes the digitized VCO clock and divides it down to a comparison frequency for the phase detector. It has two division paths.

The swallow path models a dual-modulus prescaler. The prescaler divides by M+1 while the swallow counter A is nonzero and by M after that. A main counter B counts prescaler periods. The direct path is a single counter built from both ratio fields. A standby code freezes all counting and keeps the counter contents.

The ratio fields are a high field (8 bits) and a low field (6 bits). The mode code selects between standby, two swallow codes and the direct path. A coarse-step select picks the prescaler base modulus and the width of the swallow counter. In steady state the output is a single one-clock pulse every N input clocks. New settings are taken up when a division cycle ends, so the period never has a gap.

Top module: `fbdiv_top`

## Requirements
- R1: In a swallow mode with coarse_step_i=0, the base modulus is 64 and A is div_lo_i (6 bits). The pulse period is 64·div_hi_i + div_lo_i + 64 clocks (div_hi_i=135 and div_lo_i=56 give 8760).
- R2: In a swallow mode with coarse_step_i=1, the base modulus is 32 and A is div_lo_i[4:0]. The period is 32·div_hi_i + div_lo_i[4:0] + 32, and div_lo_i[5] has no effect (div_hi_i=135 with A=0 gives 4352, with A=28 gives 4380).
- R3: In direct mode the period is {div_hi_i, div_lo_i} + 1 clocks (a 14-bit value, div_hi_i in the upper bits), and coarse_step_i has no effect.
- R4: mode_sel_i encoding: 2'b00 standby, 2'b10 FM swallow, 2'b01 AM swallow, 2'b11 direct. Both swallow codes give the same ratio.
- R5: In standby, fsyn_o stays low and every counter holds its value. On resume the cycle in progress continues, so that interval grows by exactly the number of standby clocks.
- R6: fsyn_o is high for one clock per division cycle (for N>1). Ratio and mode changes take effect at the next division-cycle boundary.
- R7: illegal_o goes high one clock after a swallow mode is selected with div_hi_i < A. Counting continues deterministically, with a period of M·(div_hi_i+1) + min(A, div_hi_i+1).
- R8: While rst_ni is low, fsyn_o and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Digitized VCO clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_hi_i | input | 8 | Main counter value B / upper direct ratio bits |
| div_lo_i | input | 6 | Swallow value A / lower direct ratio bits |
| mode_sel_i | input | 2 | Mode code (standby, FM swallow, AM swallow, direct) |
| coarse_step_i | input | 1 | 1 selects modulus 32/33 and a 5-bit swallow counter |
| fsyn_o | output | 1 | One-clock pulse per division cycle |
| illegal_o | output | 1 | Swallow setting with B below A |

## Verification
The in-RTL properties check the following on every clock:
- the prescaler count never exceeds the latched modulus;
- a drained swallow counter stays at zero until a reload;
- the direct counter holds while stalled and always reloads at zero;
- standby silences the output;
- the illegal flag appears only after a swallow code.

The absolute division ratios can only be shown by the bench scenarios. These include the worked tuning values, the ignored swallow bit in 5-bit mode, the equivalence of the two swallow codes and the period in the illegal case. They also include the exact growth of an interval when standby interrupts it mid-cycle.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  typedef enum logic [1:0] {
    MODE_STBY   = 2'b00,
    MODE_AM_SW  = 2'b01,
    MODE_FM_SW  = 2'b10,
    MODE_DIRECT = 2'b11
  } mode_e;

  typedef enum logic {
    PATH_SWALLOW = 1'b0,
    PATH_DIRECT  = 1'b1
  } path_e;
endpackage

// File: rtl/fbdiv_decode.sv
module fbdiv_decode
  import fbdiv_pkg::*;
#(
  parameter int PC_W = 8,
  parameter int SC_W = 6
) (
  input  logic [PC_W-1:0]      div_hi_i,
  input  logic [SC_W-1:0]      div_lo_i,
  input  logic [1:0]           mode_sel_i,
  input  logic                 coarse_step_i,
  output logic                 standby_o,
  output path_e                path_o,
  output logic [SC_W:0]        mod_base_o,
  output logic [SC_W-1:0]      a_val_o,
  output logic [PC_W-1:0]      b_val_o,
  output logic [PC_W+SC_W-1:0] c_val_o,
  output logic                 illegal_o
);
  localparam logic [SC_W:0] MOD_FINE   = (SC_W+1)'(1) << SC_W;
  localparam logic [SC_W:0] MOD_COARSE = (SC_W+1)'(1) << (SC_W-1);

  mode_e mode;
  assign mode      = mode_e'(mode_sel_i);
  assign standby_o = (mode == MODE_STBY);
  assign path_o    = (mode == MODE_DIRECT) ? PATH_DIRECT : PATH_SWALLOW;

  assign mod_base_o = coarse_step_i ? MOD_COARSE : MOD_FINE;
  // top swallow bit is dropped in the 5-bit case
  assign a_val_o    = coarse_step_i ? {1'b0, div_lo_i[SC_W-2:0]} : div_lo_i;
  assign b_val_o    = div_hi_i;
  assign c_val_o    = {div_hi_i, div_lo_i};

  // assumes PC_W >= SC_W
  assign illegal_o = !standby_o && (path_o == PATH_SWALLOW) &&
                     (div_hi_i < {{(PC_W-SC_W){1'b0}}, a_val_o});
endmodule

// File: rtl/fbdiv_swallow_core.sv
module fbdiv_swallow_core #(
  parameter int PC_W = 8,
  parameter int SC_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            load_i,
  input  logic [SC_W:0]   mod_base_i,
  input  logic [SC_W-1:0] a_val_i,
  input  logic [PC_W-1:0] b_val_i,
  output logic            term_o
);
  localparam int PRE_W = SC_W + 1;

  logic [PRE_W-1:0] pre_q, m_q;
  logic [SC_W-1:0]  a_q, a_next;
  logic [PC_W-1:0]  b_q;

  assign a_next = (a_q != '0) ? a_q - 1'b1 : '0;
  assign term_o = (pre_q == '0) && (b_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      m_q   <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (load_i) begin
      m_q   <= mod_base_i;
      a_q   <= a_val_i;
      b_q   <= b_val_i;
      // prescaler count holds modulus-1; M+1 while A is pending
      pre_q <= (a_val_i != '0) ? mod_base_i : mod_base_i - 1'b1;
    end else if (en_i) begin
      if (pre_q == '0) begin
        a_q   <= a_next;
        b_q   <= b_q - 1'b1;
        pre_q <= (a_next != '0) ? m_q : m_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= m_q); // R1
  AST_A_STAYS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_q == '0 && !load_i) |=> (a_q == '0)); // R1
endmodule

// File: rtl/fbdiv_direct_core.sv
module fbdiv_direct_core #(
  parameter int C_W = 14
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           load_i,
  input  logic [C_W-1:0] c_val_i,
  output logic           term_o
);
  logic [C_W-1:0] c_q;

  assign term_o = (c_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     c_q <= '0;
    else if (load_i) c_q <= c_val_i;
    else if (en_i)   c_q <= c_q - 1'b1;
  end

  AST_DIRECT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(c_q)); // R5
  AST_DIRECT_TERM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && c_q == '0) |-> load_i); // R3
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int PC_W = 8,
  parameter int SC_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] div_hi_i,
  input  logic [SC_W-1:0] div_lo_i,
  input  logic [1:0]      mode_sel_i,
  input  logic            coarse_step_i,
  output logic            fsyn_o,
  output logic            illegal_o
);
  localparam int C_W = PC_W + SC_W;

  logic            standby, illegal_d;
  path_e           path_d, path_q;
  logic [SC_W:0]   mod_base;
  logic [SC_W-1:0] a_val;
  logic [PC_W-1:0] b_val;
  logic [C_W-1:0]  c_val;
  logic            running_q, fsyn_q, illegal_q;
  logic            s_term, d_term, term, load, s_en, d_en;

  fbdiv_decode #(.PC_W(PC_W), .SC_W(SC_W)) u_decode (
    .div_hi_i      (div_hi_i),
    .div_lo_i      (div_lo_i),
    .mode_sel_i    (mode_sel_i),
    .coarse_step_i (coarse_step_i),
    .standby_o     (standby),
    .path_o        (path_d),
    .mod_base_o    (mod_base),
    .a_val_o       (a_val),
    .b_val_o       (b_val),
    .c_val_o       (c_val),
    .illegal_o     (illegal_d)
  );

  assign term = (path_q == PATH_DIRECT) ? d_term : s_term;
  assign load = !standby && (!running_q || term);
  assign s_en = !standby && running_q && (path_q == PATH_SWALLOW);
  assign d_en = !standby && running_q && (path_q == PATH_DIRECT);

  fbdiv_swallow_core #(.PC_W(PC_W), .SC_W(SC_W)) u_swallow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (s_en),
    .load_i     (load),
    .mod_base_i (mod_base),
    .a_val_i    (a_val),
    .b_val_i    (b_val),
    .term_o     (s_term)
  );

  fbdiv_direct_core #(.C_W(C_W)) u_direct (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (d_en),
    .load_i  (load),
    .c_val_i (c_val),
    .term_o  (d_term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      path_q    <= PATH_SWALLOW;
      fsyn_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= illegal_d;
      if (standby) begin
        fsyn_q <= 1'b0;
      end else begin
        fsyn_q <= running_q && term;
        if (load) begin
          running_q <= 1'b1;
          path_q    <= path_d;
        end
      end
    end
  end

  assign fsyn_o    = fsyn_q;
  assign illegal_o = illegal_q;

  AST_STBY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i == MODE_STBY) |=> !fsyn_o); // R5
  AST_FLAG_SWALLOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(mode_sel_i == MODE_AM_SW || mode_sel_i == MODE_FM_SW)); // R7
endmodule

// File: tb/tb_fbdiv_top.sv
module tb_fbdiv_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_hi = '0;
  logic [5:0] div_lo = '0;
  logic [1:0] mode = 2'b00;
  logic       coarse = 1'b0;
  logic       fsyn, illegal;

  int vectors = 0, errors = 0;
  int cyc = 0, last_pulse = 0, pulse_cnt = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbdiv_top dut (
    .clk_i(clk), .rst_ni(rst_n), .div_hi_i(div_hi), .div_lo_i(div_lo),
    .mode_sel_i(mode), .coarse_step_i(coarse), .fsyn_o(fsyn), .illegal_o(illegal)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures pulse intervals and pops expectations
  always @(negedge clk) begin
    cyc++;
    if (fsyn) begin
      if (exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check((cyc - last_pulse) == e, t, cyc - last_pulse, e);
      end
      last_pulse = cyc;
      pulse_cnt++;
    end
  end

  task automatic push(int period, int reps, string tag);
    for (int i = 0; i < reps; i++) begin
      exp_q.push_back(period);
      tag_q.push_back(tag);
    end
  endtask

  task automatic wait_pulse();
    int start;
    @(posedge clk);
    start = pulse_cnt;
    wait (pulse_cnt == start + 1);
  endtask

  // driver: apply settings, skip to first boundary, then expect intervals
  task automatic apply(logic [7:0] hi, logic [5:0] lo, logic [1:0] m, logic cs,
                       int period, int reps, string tag);
    @(negedge clk);
    div_hi = hi; div_lo = lo; mode = m; coarse = cs;
    wait_pulse();
    push(period, reps, tag);
    wait (exp_q.size() == 0);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", WDOG_CYC, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    check(fsyn == 1'b0, "R8 fsyn in reset", fsyn, 0);
    check(illegal == 1'b0, "R8 illegal in reset", illegal, 0);
    @(negedge clk) rst_n = 1'b1;

    // R5: standby after reset gives no pulses
    p0 = pulse_cnt;
    repeat (300) @(negedge clk);
    check(pulse_cnt == p0, "R5 standby silent", pulse_cnt - p0, 0);

    // R2: coarse step worked values
    apply(8'd135, 6'd0,  2'b10, 1'b1, 4352, 2, "R2 coarse sc0");
    apply(8'd135, 6'd28, 2'b10, 1'b1, 4380, 1, "R2 coarse sc28");
    apply(8'd135, 6'd60, 2'b10, 1'b1, 4380, 1, "R2 bit5 ignored");
    // R4: AM swallow code behaves like FM swallow
    apply(8'd135, 6'd28, 2'b01, 1'b1, 4380, 1, "R4 am swallow code");
    // R1: fine step
    apply(8'd135, 6'd56, 2'b10, 1'b0, 8760, 1, "R1 fine sc56");
    apply(8'd70,  6'd5,  2'b01, 1'b0, 64*71+5, 1, "R1 am fine");
    check(illegal == 1'b0, "R7 legal flag low", illegal, 0);
    // R3: direct, coarse_step_i ignored
    apply(8'd15, 6'd19, 2'b11, 1'b1, 980, 2, "R3 direct 979");
    apply(8'd33, 6'd47, 2'b11, 1'b0, 2160, 1, "R3 direct 2159");
    // R6: short ratio, single-cycle pulses
    apply(8'd0, 6'd5, 2'b11, 1'b0, 6, 4, "R6 direct 5");
    // R7: B < A still counts deterministically
    apply(8'd3, 6'd10, 2'b10, 1'b0, 260, 2, "R7 illegal period");
    check(illegal == 1'b1, "R7 illegal flag high", illegal, 1);
    apply(8'd40, 6'd3, 2'b10, 1'b1, 32*41+3, 1, "R7 recover");
    check(illegal == 1'b0, "R7 flag clears", illegal, 0);

    // R5: mid-cycle standby extends the interval by its length
    apply(8'd15, 6'd39, 2'b11, 1'b0, 1000, 1, "R3 direct 999");
    wait_pulse();
    push(1250, 1, "R5 resume interval");
    push(1000, 1, "R5 after resume");
    repeat (100) @(negedge clk);
    mode = 2'b00;
    p0 = pulse_cnt;
    repeat (250) @(negedge clk);
    check(pulse_cnt == p0, "R5 pause silent", pulse_cnt - p0, 0);
    mode = 2'b11;
    wait (exp_q.size() == 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule